// File: doc/BRIEF.md
# Relocatable SRAM Bus Decoder

This block is the address front end for an on-chip 8 KB SRAM whose window can be moved anywhere in a 32-bit address space. On every bus request it compares the upper address bits with a programmable base. It checks the function code against a configured access-space mode and checks that the transfer size is legal. It then either claims the cycle for the array, with byte lanes and an array offset, or stays silent so that another responder on the bus can answer. Storage above a configurable implemented size is never claimed.

An 8-byte control block sits at a fixed address and holds two words. The word at offset 0 holds the space mode, and the word at offset 4 holds the window base. The control block answers only supervisor data accesses. Wherever the array window overlaps it, those 8 bytes never reach the array.

All decode results are registered, so the outputs reflect the request presented one clock earlier. Only the master reset clears the configuration.

Top module: `sdec_top`

## Requirements
- R1: A request is claimed by the array (`arr_sel`=1 one cycle later) when `bus_valid`=1, `bus_addr[31:13]` equals the stored base, the offset is implemented, the function code is allowed and the size is legal. In that case `arr_offset` equals `bus_addr[12:0]`. Addresses outside the window are not claimed.
- R2: Offsets at or above `IMPL_BYTES` (default 7168, 0x1C00) inside the window are not claimed.
- R3: The control block occupies the 8 bytes at `REG_BASE` (default 0xFFFFF040). The array never claims those bytes, even when its window covers them. `arr_sel` and `reg_sel` are never both 1.
- R4: Space mode bit 1 set means supervisor-only, so user codes 1 and 2 are not claimed. With bit 1 clear, both user and supervisor codes are claimed.
- R5: Space mode bit 0 set means program-only, so only codes 2 and 6 are claimed. With bit 0 clear, data codes 1 and 5 are claimed as well.
- R6: Function codes 0, 3, 4 and 7 are never claimed by the array or by the control block.
- R7: Byte lanes (bit k = data bits 8k+7..8k) are set as follows. Size 00 (long) gives 1111. Size 01 (byte) gives 1 shifted left by `bus_addr[1:0]`. Size 10 (word) gives 1100 when `bus_addr[1]`=1 and 0011 otherwise. Lanes are 0 whenever nothing is claimed.
- R8: Size 11 is reserved and is never claimed.
- R9: The control block answers (`reg_sel`=1) only function code 5. Other codes neither claim it nor change it. `rd_data` is 0 except on a control-block read.
- R10: In the word at `REG_BASE`+0, bits [1:0] hold the space mode. The word at `REG_BASE`+4 holds the base in bits [31:13]. All other bits read 0 and drop writes. Writes update only the enabled byte lanes. Read data is masked to the enabled lanes.
- R11: Master reset clears the mode to 00 and the base to 0, and clears all outputs. Outputs follow a request by exactly one clock.
- R12: With `bus_valid`=0 nothing is claimed and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low |
| bus_valid | input | 1 | Request present |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Transfer size code |
| bus_wr | input | 1 | 1 = write |
| bus_fc | input | 3 | Function code |
| bus_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| arr_sel | output | 1 | Array claims the request |
| arr_lanes | output | 4 | Byte lane enables |
| arr_offset | output | 13 | Byte offset inside the array |
| reg_sel | output | 1 | Control block claims the request |
| rd_data | output | 32 | Control-block read data |

## Verification
The bench moves the window so that it covers the control block. It then checks that user accesses to those 8 bytes go unclaimed, and that the neighbouring bytes still reach the array. A decoder without this override would hand the bytes to the array. The bench probes the offsets just below and at the implemented limit, where an off-by-one compare would claim missing storage. It sweeps every space mode against every function code, so a swapped mode bit or a leaky supervisor check shows up as a wrong claim. It also writes the control words with the wrong function code and with single-byte lanes, then reads them back, which catches unfiltered writes, whole-word writes and unimplemented bits that hold data.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [2:0] FC_USR_DATA = 3'd1;
    localparam logic [2:0] FC_USR_PROG = 3'd2;
    localparam logic [2:0] FC_SUP_DATA = 3'd5;
    localparam logic [2:0] FC_SUP_PROG = 3'd6;

    // expand byte-lane enables into a bit mask over the data word
    function automatic logic [31:0] lane_bits(input logic [3:0] lanes);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{lanes[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sdec_lanes.sv
module sdec_lanes
    import sdec_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic [3:0] lanes,
    output logic       size_ok
);

    always_comb begin
        lanes   = 4'b0000;
        size_ok = 1'b1;
        case (size)
            SZ_LONG: lanes = 4'b1111;
            SZ_BYTE: lanes = 4'b0001 << addr_lo;
            SZ_WORD: lanes = addr_lo[1] ? 4'b1100 : 4'b0011;
            default: size_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdec_space.sv
module sdec_space
    import sdec_pkg::*;
(
    input  logic [2:0] fc,
    input  logic [1:0] mode,
    output logic       allow
);

    logic is_user;
    logic is_sup;
    logic is_prog;

    always_comb begin
        is_user = (fc == FC_USR_DATA) || (fc == FC_USR_PROG);
        is_sup  = (fc == FC_SUP_DATA) || (fc == FC_SUP_PROG);
        is_prog = (fc == FC_USR_PROG) || (fc == FC_SUP_PROG);
        // mode[1]: supervisor only, mode[0]: program only
        allow   = (is_user || is_sup)
                  && !(mode[1] && !is_sup)
                  && !(mode[0] && !is_prog);
    end

endmodule

// File: rtl/sdec_regs.sv
module sdec_regs
    import sdec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ARRAY_BITS = 13,
    localparam int BASE_W    = ADDR_W - ARRAY_BITS
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              wr_en,
    input  logic              word_sel,
    input  logic [3:0]        lanes,
    input  logic [31:0]       wdata,
    output logic [1:0]        mode,
    output logic [BASE_W-1:0] base,
    output logic [31:0]       rd_word
);

    typedef struct packed {
        logic [1:0]        mode;
        logic [BASE_W-1:0] base;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [31:0]       cfg_word;
    logic [31:0]       base_word;
    logic [31:0]       mask;
    logic [31:0]       merged;
    logic [ADDR_W-1:0] merged_a;

    always_comb begin
        cfg_word  = {30'b0, cfg_q.mode};
        base_word = 32'({cfg_q.base, {ARRAY_BITS{1'b0}}});
        rd_word   = word_sel ? base_word : cfg_word;
        mask      = lane_bits(lanes);
        merged    = (rd_word & ~mask) | (wdata & mask);
        merged_a  = ADDR_W'(merged);
        cfg_d     = cfg_q;
        if (wr_en) begin
            if (word_sel) begin
                cfg_d.base = merged_a[ADDR_W-1:ARRAY_BITS];
            end else begin
                cfg_d.mode = merged[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode = cfg_q.mode;
    assign base = cfg_q.base;

endmodule

// File: rtl/sdec_top.sv
module sdec_top
    import sdec_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              ARRAY_BITS = 13,
    parameter int              IMPL_BYTES = 7168,
    parameter logic [ADDR_W-1:0] REG_BASE = 32'hFFFF_F040
) (
    input  logic                  clk,
    input  logic                  mrst_n,
    input  logic                  bus_valid,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic                  bus_wr,
    input  logic [2:0]            bus_fc,
    input  logic [31:0]           bus_wdata,
    output logic                  arr_sel,
    output logic [3:0]            arr_lanes,
    output logic [ARRAY_BITS-1:0] arr_offset,
    output logic                  reg_sel,
    output logic [31:0]           rd_data
);

    localparam int BASE_W = ADDR_W - ARRAY_BITS;
    localparam logic [ARRAY_BITS:0] IMPL_LIM = (ARRAY_BITS + 1)'(IMPL_BYTES);

    typedef struct packed {
        logic                  arr;
        logic                  rg;
        logic [3:0]            lanes;
        logic [ARRAY_BITS-1:0] off;
        logic [31:0]           rd;
    } out_t;

    out_t              out_d, out_q;
    logic [3:0]        lanes;
    logic              size_ok;
    logic              allow;
    logic [1:0]        cfg_mode;
    logic [BASE_W-1:0] cfg_base;
    logic [31:0]       rd_word;
    logic              reg_hit;
    logic              win_hit;
    logic              impl_hit;
    logic              reg_acc;
    logic              arr_acc;
    logic              reg_wr;

    sdec_lanes u_lanes (
        .size    (bus_size),
        .addr_lo (bus_addr[1:0]),
        .lanes   (lanes),
        .size_ok (size_ok)
    );

    sdec_space u_space (
        .fc    (bus_fc),
        .mode  (cfg_mode),
        .allow (allow)
    );

    sdec_regs #(
        .ADDR_W     (ADDR_W),
        .ARRAY_BITS (ARRAY_BITS)
    ) u_regs (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .wr_en    (reg_wr),
        .word_sel (bus_addr[2]),
        .lanes    (lanes),
        .wdata    (bus_wdata),
        .mode     (cfg_mode),
        .base     (cfg_base),
        .rd_word  (rd_word)
    );

    always_comb begin
        reg_hit  = bus_addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3];
        win_hit  = bus_addr[ADDR_W-1:ARRAY_BITS] == cfg_base;
        impl_hit = {1'b0, bus_addr[ARRAY_BITS-1:0]} < IMPL_LIM;
        reg_acc  = bus_valid && size_ok && reg_hit && (bus_fc == FC_SUP_DATA);
        arr_acc  = bus_valid && size_ok && win_hit && impl_hit && !reg_hit && allow;
        reg_wr   = reg_acc && bus_wr;

        out_d       = '0;
        out_d.arr   = arr_acc;
        out_d.rg    = reg_acc;
        out_d.lanes = (arr_acc || reg_acc) ? lanes : 4'b0000;
        out_d.off   = arr_acc ? bus_addr[ARRAY_BITS-1:0] : '0;
        out_d.rd    = (reg_acc && !bus_wr) ? (rd_word & lane_bits(lanes)) : 32'b0;
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign arr_sel    = out_q.arr;
    assign reg_sel    = out_q.rg;
    assign arr_lanes  = out_q.lanes;
    assign arr_offset = out_q.off;
    assign rd_data    = out_q.rd;

endmodule

// File: rtl/sdec_checker.sv
module sdec_checker #(
    parameter int ARRAY_BITS = 13,
    parameter int IMPL_BYTES = 7168
) (
    input logic                  clk,
    input logic                  mrst_n,
    input logic                  bus_valid,
    input logic [2:0]            bus_fc,
    input logic [1:0]            mode,
    input logic                  arr_sel,
    input logic                  reg_sel,
    input logic [3:0]            arr_lanes,
    input logic [ARRAY_BITS-1:0] arr_offset,
    input logic [31:0]           rd_data
);

    localparam logic [ARRAY_BITS:0] LIM = (ARRAY_BITS + 1)'(IMPL_BYTES);

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!mrst_n)
        !(arr_sel && reg_sel));

    a_r2_impl_limit: assert property (@(posedge clk) disable iff (!mrst_n)
        arr_sel |-> ({1'b0, arr_offset} < LIM));

    a_r4_user_blocked: assert property (@(posedge clk) disable iff (!mrst_n)
        (bus_valid && !bus_fc[2] && mode[1]) |=> !arr_sel);

    a_r5_prog_only: assert property (@(posedge clk) disable iff (!mrst_n)
        (bus_valid && mode[0] && (bus_fc != 3'd2) && (bus_fc != 3'd6)) |=> !arr_sel);

    a_r6_bad_fc: assert property (@(posedge clk) disable iff (!mrst_n)
        (bus_valid && (bus_fc[1:0] == 2'b00 || bus_fc[1:0] == 2'b11)) |=> (!arr_sel && !reg_sel));

    a_r7_lane_shape: assert property (@(posedge clk) disable iff (!mrst_n)
        (arr_sel || reg_sel) |-> ($countones(arr_lanes) == 1 || $countones(arr_lanes) == 2
                                  || $countones(arr_lanes) == 4));

    a_r9_sup_data_only: assert property (@(posedge clk) disable iff (!mrst_n)
        reg_sel |-> ($past(bus_fc) == 3'd5));

    a_r9_quiet_data: assert property (@(posedge clk) disable iff (!mrst_n)
        !reg_sel |-> (rd_data == 32'b0));

    a_r12_idle: assert property (@(posedge clk) disable iff (!mrst_n)
        !bus_valid |=> (!arr_sel && !reg_sel && arr_lanes == 4'b0000));

endmodule

bind sdec_top sdec_checker #(
    .ARRAY_BITS (ARRAY_BITS),
    .IMPL_BYTES (IMPL_BYTES)
) u_chk (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .bus_valid  (bus_valid),
    .bus_fc     (bus_fc),
    .mode       (cfg_mode),
    .arr_sel    (arr_sel),
    .reg_sel    (reg_sel),
    .arr_lanes  (arr_lanes),
    .arr_offset (arr_offset),
    .rd_data    (rd_data)
);

// File: tb/sim_sdec_top.sv
module sim_sdec_top;

    localparam logic [31:0] RB = 32'hFFFF_F040;

    typedef struct {
        logic        arr;
        logic        rg;
        logic [3:0]  lanes;
        logic [12:0] off;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_fc = '0;
    logic [31:0] bus_wdata = '0;
    logic        arr_sel;
    logic [3:0]  arr_lanes;
    logic [12:0] arr_offset;
    logic        reg_sel;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t q[$];
    logic [1:0]  mode_m = 2'b00;
    logic [18:0] base_m = '0;

    always #4 clk = ~clk;

    sdec_top u0 (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wr     (bus_wr),
        .bus_fc     (bus_fc),
        .bus_wdata  (bus_wdata),
        .arr_sel    (arr_sel),
        .arr_lanes  (arr_lanes),
        .arr_offset (arr_offset),
        .reg_sel    (reg_sel),
        .rd_data    (rd_data)
    );

    function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 4'b1111;
            2'b01:   return 4'b0001 << a;
            2'b10:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] lmask(input logic [3:0] l);
        return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
    endfunction

    // driver: applies one request and pushes the expected registered result
    task automatic acc(input logic v, input logic [31:0] a, input logic [1:0] sz,
                       input logic w, input logic [2:0] fc, input logic [31:0] wd,
                       input string tag);
        exp_t e;
        logic [3:0]  ln;
        logic [31:0] word, mrg;
        logic szok, rhit, known, sup, prog, allow;
        ln    = exp_lanes(sz, a[1:0]);
        szok  = (sz != 2'b11);
        rhit  = (a[31:3] == RB[31:3]);
        sup   = (fc == 3'd5) || (fc == 3'd6);
        prog  = (fc == 3'd2) || (fc == 3'd6);
        known = sup || (fc == 3'd1) || (fc == 3'd2);
        allow = known && !(mode_m[1] && !sup) && !(mode_m[0] && !prog);
        e.arr = v && szok && !rhit && allow && (a[31:13] == base_m) && (a[12:0] < 13'h1C00);
        e.rg  = v && szok && rhit && (fc == 3'd5);
        e.lanes = (e.arr || e.rg) ? ln : 4'b0000;
        e.off   = e.arr ? a[12:0] : 13'd0;
        word    = a[2] ? {base_m, 13'b0} : {30'b0, mode_m};
        e.rd    = (e.rg && !w) ? (word & lmask(ln)) : 32'b0;
        e.tag   = tag;
        if (e.rg && w) begin
            mrg = (word & ~lmask(ln)) | (wd & lmask(ln));
            if (a[2]) base_m = mrg[31:13];
            else      mode_m = mrg[1:0];
        end
        @(negedge clk);
        bus_valid = v;
        bus_addr  = a;
        bus_size  = sz;
        bus_wr    = w;
        bus_fc    = fc;
        bus_wdata = wd;
        q.push_back(e);
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] fc, input string tag);
        acc(1'b1, a, sz, 1'b0, fc, 32'h0, tag);
    endtask

    task automatic wrr(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] fc,
                       input logic [31:0] d, input string tag);
        acc(1'b1, a, sz, 1'b1, fc, d, tag);
    endtask

    task automatic idle(input string tag);
        acc(1'b0, 32'h0, 2'b00, 1'b0, 3'd0, 32'h0, tag);
    endtask

    task automatic chk_zero(input string tag);
        n_cmp++;
        if (arr_sel || reg_sel || arr_lanes != 0 || arr_offset != 0 || rd_data != 0) begin
            n_bad++;
            $display("FAIL %s: got arr=%0b reg=%0b lanes=%h off=%h rd=%h, expected all zero",
                     tag, arr_sel, reg_sel, arr_lanes, arr_offset, rd_data);
        end
    endtask

    // monitor: compares one registered result per clock against the queue
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (arr_sel !== e.arr || reg_sel !== e.rg || arr_lanes !== e.lanes ||
                arr_offset !== e.off || rd_data !== e.rd) begin
                n_bad++;
                $display("FAIL %s: got arr=%0b reg=%0b lanes=%h off=%h rd=%h, expected arr=%0b reg=%0b lanes=%h off=%h rd=%h",
                         e.tag, arr_sel, reg_sel, arr_lanes, arr_offset, rd_data,
                         e.arr, e.rg, e.lanes, e.off, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 chk_zero("R11 outputs in reset");
        @(negedge clk) mrst_n = 1'b1;

        // R11 / R10: reset contents of both control words
        rd(RB,      2'b00, 3'd5, "R11 mode reset value");
        rd(RB + 4,  2'b00, 3'd5, "R11 base reset value");

        // R10: base programming, unimplemented bits dropped
        wrr(RB + 4, 2'b00, 3'd5, 32'h0002_01FF, "R10 base write");
        rd(RB + 4,  2'b00, 3'd5, "R10 base readback low bits zero");
        wrr(RB,     2'b00, 3'd5, 32'hFFFF_FFFC, "R10 mode write upper bits");
        rd(RB,      2'b00, 3'd5, "R10 mode readback");

        // R1 / R7: window hits with lane patterns
        rd(32'h0002_0000, 2'b01, 3'd1, "R1 byte at base");
        rd(32'h0002_0003, 2'b01, 3'd1, "R7 byte lane 3");
        rd(32'h0002_0002, 2'b10, 3'd1, "R7 upper word");
        rd(32'h0002_0000, 2'b10, 3'd5, "R7 lower word");
        wrr(32'h0002_0104, 2'b00, 3'd1, 32'h1234_5678, "R7 long write");
        rd(32'h0001_FFFF, 2'b01, 3'd1, "R1 below window");
        rd(32'h0002_2000, 2'b01, 3'd1, "R1 above window");

        // R2: implemented limit
        rd(32'h0002_1BFF, 2'b01, 3'd1, "R2 last implemented byte");
        rd(32'h0002_1C00, 2'b01, 3'd1, "R2 first missing byte");
        rd(32'h0002_1FFC, 2'b00, 3'd1, "R2 window top");

        // R8 / R6
        rd(32'h0002_0010, 2'b11, 3'd1, "R8 reserved size array");
        rd(RB,            2'b11, 3'd5, "R8 reserved size regs");
        for (int f = 0; f < 8; f++) begin
            if (f == 0 || f == 3 || f == 4 || f == 7) begin
                rd(32'h0002_0020, 2'b00, 3'(f), "R6 undefined code array");
                rd(RB,            2'b00, 3'(f), "R6 undefined code regs");
            end
        end

        // R4 / R5: each mode against each defined code
        for (int m = 0; m < 4; m++) begin
            wrr(RB, 2'b01, 3'd5, 32'(m), "R10 mode byte write");
            rd(32'h0002_0040, 2'b00, 3'd1, "R4 R5 user data");
            rd(32'h0002_0040, 2'b00, 3'd2, "R4 R5 user program");
            rd(32'h0002_0040, 2'b00, 3'd5, "R4 R5 supervisor data");
            rd(32'h0002_0040, 2'b00, 3'd6, "R4 R5 supervisor program");
        end
        wrr(RB, 2'b00, 3'd5, 32'h0, "R10 mode clear");

        // R9: wrong codes neither claim nor modify
        wrr(RB,     2'b00, 3'd1, 32'h3, "R9 user write ignored");
        wrr(RB + 4, 2'b00, 3'd6, 32'hFFFF_E000, "R9 supervisor program write ignored");
        rd(RB,      2'b00, 3'd2, "R9 user read ignored");
        rd(RB,      2'b00, 3'd5, "R9 mode unchanged");
        rd(RB + 4,  2'b00, 3'd5, "R9 base unchanged");

        // R10: single-lane write and masked reads
        wrr(RB + 6, 2'b01, 3'd5, 32'h00AB_0000, "R10 base byte lane 2 write");
        rd(RB + 4,  2'b00, 3'd5, "R10 base after byte write");
        rd(RB + 6,  2'b01, 3'd5, "R10 masked byte read lane 2");
        rd(RB + 4,  2'b10, 3'd5, "R10 masked word read low lanes");

        // R3: window over the control block
        wrr(RB + 4, 2'b00, 3'd5, 32'hFFFF_E000, "R3 move window over regs");
        rd(RB,      2'b00, 3'd1, "R3 user on control bytes");
        rd(RB + 7,  2'b01, 3'd2, "R3 user program on control bytes");
        rd(RB + 8,  2'b01, 3'd1, "R3 byte after control block");
        rd(RB - 1,  2'b01, 3'd1, "R3 byte before control block");
        rd(RB,      2'b00, 3'd5, "R3 supervisor data gets regs");

        // R12: no request, addresses that would hit
        acc(1'b0, RB + 8, 2'b00, 1'b0, 3'd1, 32'h0, "R12 idle window address");
        acc(1'b0, RB,     2'b00, 1'b0, 3'd5, 32'h0, "R12 idle register address");
        idle("R12 idle");
        idle("R12 drain");

        // R11: master reset returns configuration to defaults
        @(negedge clk) mrst_n = 1'b0;
        mode_m = 2'b00;
        base_m = '0;
        #2 chk_zero("R11 outputs during master reset");
        @(negedge clk) mrst_n = 1'b1;
        rd(RB + 4, 2'b00, 3'd5, "R11 base after master reset");
        rd(32'h0000_0100, 2'b01, 3'd1, "R11 window at zero after reset");
        idle("final drain");
        idle("final drain");
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule